// File: doc/BRIEF.md
# General-purpose I/O bank with set and clear strobes

This block is one bank of up to 64 general-purpose I/O lines. A simple memory-mapped register port controls it. The port carries 64-bit write and read data and byte addresses that are aligned to 8-byte words.

Software never writes the output latch directly. One offset sets every latch bit written as 1, and another offset clears every latch bit written as 1. Each line has its own configuration word with four fields: an output-enable bit, a polarity-invert bit, an open-drain bit and a pin-function select.

The invert bit acts on both directions. The pad value is the latch XOR invert, and the input data read back is the filtered pad value XOR the same invert. A line behaves as a GPIO only while its function select is zero. Otherwise the bank neither enables nor drives that pad.

Glitch filtering happens upstream, so the input arrives already filtered. The bank registers its pad-facing outputs. A read answers one cycle after it is issued.

Top module: `gpio_bank`

## Requirements
- R1: A read of offset 0x0 returns, in bit n, the filtered input of line n XOR that line's invert bit, as sampled on the accepting edge.
- R2: A write to offset 0x8 sets every latch bit whose write bit is 1. A write to offset 0x10 clears every latch bit whose write bit is 1. Bits written as 0 keep their value.
- R3: A read of offset 0x8 returns the output latch. A read of offset 0x10 returns 0.
- R4: The configuration word of line n is at offset 0x400 + 8*n and has four fields: bit 0 output enable, bit 1 invert, bit 12 open-drain, and bits 25:16 function select. A write stores only these fields, and a read returns them with every other bit 0.
- R5: A line whose function select is nonzero has pad_oe 0 and pad_out 0. A line whose function select is zero and whose output-enable bit is 0 has pad_oe 0.
- R6: For a GPIO line, the pad value v is latch XOR invert. With open-drain clear, pad_out = v and pad_oe = output enable. With open-drain set, pad_out = 0 and pad_oe = output enable AND NOT v. The pad outputs take on the state reached after a clock edge on the following edge.
- R7: A read of offset 0x90 returns the line count in bits 7:0 and the base interrupt vector number in bits 15:8, with all other bits 0. Writes to 0x90 change nothing.
- R8: While reset is held, and after it, every configuration word is 0, the latch is 0, pad_oe and pad_out are 0, and bus_rdata is 0.
- R9: A read of any other offset returns 0. This includes offsets whose low three bits are nonzero and configuration offsets past the last line. Writes to such offsets, and writes to 0x0, change nothing.
- R10: bus_rdata changes only on an edge that accepts a read and holds its value until the next read. A read and a write in the same cycle return the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, data valid in the next cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| pad_in_filt | input | 64 | Filtered pad input per line |
| pad_out | output | 64 | Registered pad output value per line |
| pad_oe | output | 64 | Registered pad output enable per line |

## Verification
A wrong latch or configuration bit shows up on pad_out or pad_oe one edge after the state changes. A corrupted invert bit also flips the matching bit of the next input-data read. A stale function select or open-drain field appears as a pad driven high, or driven at all, on a line that should be released, and the next readback of that configuration word shows the bad field directly. A decode fault either alters state that a later read or the pad outputs expose within a cycle, or returns nonzero data from an offset that must read as zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned OFF_INDATA = 32'h000;
  localparam int unsigned OFF_SET    = 32'h008;
  localparam int unsigned OFF_CLR    = 32'h010;
  localparam int unsigned OFF_CONST  = 32'h090;
  localparam int unsigned OFF_CFG    = 32'h400;

  localparam int OE_BIT  = 0;
  localparam int INV_BIT = 1;
  localparam int OD_BIT  = 12;
  localparam int SEL_LSB = 16;
  localparam int SEL_W   = 10;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_INDATA,
    SRC_LATCH,
    SRC_CFG,
    SRC_CONST
  } rd_src_e;
endpackage

// File: rtl/gpio_bank_regdec.sv
module gpio_bank_regdec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINES  = 64,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_set,
  output logic              hit_clr,
  output logic              hit_cfg,
  output logic [IDX_W-1:0]  cfg_idx,
  output rd_src_e           rd_src
);
  localparam int unsigned CFG_END = OFF_CFG + 8 * LINES;

  int unsigned a;
  logic        aligned;

  always_comb begin
    a       = 32'(addr);
    aligned = (addr[2:0] == 3'b000);
    hit_set = aligned && (a == OFF_SET);
    hit_clr = aligned && (a == OFF_CLR);
    hit_cfg = aligned && (a >= OFF_CFG) && (a < CFG_END);
    cfg_idx = IDX_W'((a - OFF_CFG) >> 3);
    rd_src  = SRC_NONE;
    if (aligned) begin
      if (a == OFF_INDATA)     rd_src = SRC_INDATA;
      else if (a == OFF_SET)   rd_src = SRC_LATCH;
      else if (a == OFF_CONST) rd_src = SRC_CONST;
      else if (hit_cfg)        rd_src = SRC_CFG;
    end
  end
endmodule

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg
  import gpio_bank_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             oe_in,
  input  logic             inv_in,
  input  logic             od_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             rd_en,
  output logic [LINES-1:0] oe_mask,
  output logic [LINES-1:0] inv_mask,
  output logic [LINES-1:0] od_mask,
  output logic [LINES-1:0] gpio_mask,
  output logic             rd_oe,
  output logic             rd_inv,
  output logic             rd_od,
  output logic [SEL_W-1:0] rd_sel
);
  // function select kept in a RAM without reset; gpio_mask tells whether it is zero
  logic [SEL_W-1:0] sel_mem [LINES];
  logic [SEL_W-1:0] sel_q;
  logic             gpio_q;

  always_ff @(posedge clk) begin
    if (wr_en) sel_mem[idx] <= sel_in;
    if (rd_en) sel_q <= sel_mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_mask   <= '0;
      inv_mask  <= '0;
      od_mask   <= '0;
      gpio_mask <= '1;
    end else if (wr_en) begin
      oe_mask[idx]   <= oe_in;
      inv_mask[idx]  <= inv_in;
      od_mask[idx]   <= od_in;
      gpio_mask[idx] <= (sel_in == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe  <= 1'b0;
      rd_inv <= 1'b0;
      rd_od  <= 1'b0;
      gpio_q <= 1'b1;
    end else if (rd_en) begin
      rd_oe  <= oe_mask[idx];
      rd_inv <= inv_mask[idx];
      rd_od  <= od_mask[idx];
      gpio_q <= gpio_mask[idx];
    end
  end

  assign rd_sel = gpio_q ? '0 : sel_q;
endmodule

// File: rtl/gpio_bank_pads.sv
module gpio_bank_pads #(
  parameter int LINES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] latch,
  input  logic [LINES-1:0] oe_mask,
  input  logic [LINES-1:0] inv_mask,
  input  logic [LINES-1:0] od_mask,
  input  logic [LINES-1:0] gpio_mask,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic v;
    assign v = latch[i] ^ inv_mask[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        pad_out[i] <= gpio_mask[i] & ~od_mask[i] & v;
        pad_oe[i]  <= gpio_mask[i] & oe_mask[i] & (~od_mask[i] | ~v);
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES    = 64,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 12,
  parameter int BASE_VEC = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  pad_in_filt,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [7:0] CNT8 = 8'(LINES);
  localparam logic [7:0] VEC8 = 8'(BASE_VEC);
  localparam logic [DATA_W-1:0] CONST_WORD = DATA_W'({VEC8, CNT8});

  logic             hit_set, hit_clr, hit_cfg;
  logic [IDX_W-1:0] cfg_idx;
  rd_src_e          rd_src;

  logic [LINES-1:0] out_latch;
  logic [LINES-1:0] oe_mask, inv_mask, od_mask, gpio_mask;
  logic             rd_oe, rd_inv, rd_od;
  logic [SEL_W-1:0] rd_sel;
  logic             cfg_rd_en;
  logic [DATA_W-1:0] hold_q;
  logic              cfg_q;
  logic [DATA_W-1:0] cfg_word;

  gpio_bank_regdec #(.ADDR_W(ADDR_W), .LINES(LINES), .IDX_W(IDX_W)) u_dec (
    .addr    (bus_addr),
    .hit_set (hit_set),
    .hit_clr (hit_clr),
    .hit_cfg (hit_cfg),
    .cfg_idx (cfg_idx),
    .rd_src  (rd_src)
  );

  assign cfg_rd_en = bus_rd && (rd_src == SRC_CFG);

  gpio_bank_cfg #(.LINES(LINES), .IDX_W(IDX_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && hit_cfg),
    .idx       (cfg_idx),
    .oe_in     (bus_wdata[OE_BIT]),
    .inv_in    (bus_wdata[INV_BIT]),
    .od_in     (bus_wdata[OD_BIT]),
    .sel_in    (bus_wdata[SEL_LSB +: SEL_W]),
    .rd_en     (cfg_rd_en),
    .oe_mask   (oe_mask),
    .inv_mask  (inv_mask),
    .od_mask   (od_mask),
    .gpio_mask (gpio_mask),
    .rd_oe     (rd_oe),
    .rd_inv    (rd_inv),
    .rd_od     (rd_od),
    .rd_sel    (rd_sel)
  );

  gpio_bank_pads #(.LINES(LINES)) u_pads (
    .clk       (clk),
    .rst       (rst),
    .latch     (out_latch),
    .oe_mask   (oe_mask),
    .inv_mask  (inv_mask),
    .od_mask   (od_mask),
    .gpio_mask (gpio_mask),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_latch <= '0;
    end else if (bus_wr && hit_set) begin
      out_latch <= out_latch | bus_wdata[LINES-1:0];
    end else if (bus_wr && hit_clr) begin
      out_latch <= out_latch & ~bus_wdata[LINES-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      cfg_q  <= 1'b0;
    end else if (bus_rd) begin
      cfg_q <= (rd_src == SRC_CFG);
      unique case (rd_src)
        SRC_INDATA: hold_q <= DATA_W'(pad_in_filt ^ inv_mask);
        SRC_LATCH:  hold_q <= DATA_W'(out_latch);
        SRC_CONST:  hold_q <= CONST_WORD;
        default:    hold_q <= '0;
      endcase
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[OE_BIT]  = rd_oe;
    cfg_word[INV_BIT] = rd_inv;
    cfg_word[OD_BIT]  = rd_od;
    cfg_word[SEL_LSB +: SEL_W] = rd_sel;
  end

  assign bus_rdata = cfg_q ? cfg_word : hold_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int LINES    = 64,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 12,
  parameter int BASE_VEC = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [LINES-1:0]  pad_out,
  input logic [LINES-1:0]  pad_oe,
  input logic [LINES-1:0]  out_latch,
  input logic [LINES-1:0]  od_mask,
  input logic [LINES-1:0]  gpio_mask
);
  localparam logic [DATA_W-1:0] EXP_CONST = DATA_W'({8'(BASE_VEC), 8'(LINES)});

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(12'h008)) |=>
      ((out_latch & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(12'h010)) |=>
      ((out_latch & $past(bus_wdata[LINES-1:0])) == '0));

  p_clr_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(12'h010)) |=> (bus_rdata == '0));

  p_nongpio_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out) & ~$past(gpio_mask)) == '0);

  p_od_never_high_r6: assert property (@(posedge clk) disable iff (rst)
    (pad_out & $past(od_mask)) == '0);

  p_const_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(12'h090)) |=> (bus_rdata == EXP_CONST));

  p_misaligned_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[2:0] != 3'b000) |=> (bus_rdata == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank gpio_bank_chk #(
  .LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_VEC(BASE_VEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .out_latch (out_latch),
  .od_mask   (od_mask),
  .gpio_mask (gpio_mask)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [63:0] pad_in_filt = '0;
  logic [63:0] pad_out, pad_oe;

  always #4 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in_filt(pad_in_filt), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] m_lat, m_oe, m_inv, m_od;
  int          m_sel [64];
  logic [63:0] exp_rd = '0, exp_out = '0, exp_oe = '0;
  string       rd_tag = "R8", pad_tag_oe = "R8", pad_tag_out = "R8";
  bit          armed = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_lat = '0; m_oe = '0; m_inv = '0; m_od = '0;
      for (int i = 0; i < 64; i++) m_sel[i] = 0;
      exp_rd = '0; exp_out = '0; exp_oe = '0;
      rd_tag = "R8"; pad_tag_oe = "R8"; pad_tag_out = "R8";
      armed = 1;
    end else begin
      int unsigned a;
      a = bus_addr;
      for (int i = 0; i < 64; i++) begin
        logic v;
        v = m_lat[i] ^ m_inv[i];
        if (m_sel[i] != 0) begin
          exp_out[i] = 1'b0; exp_oe[i] = 1'b0;
        end else if (m_od[i]) begin
          exp_out[i] = 1'b0; exp_oe[i] = m_oe[i] & ~v;
        end else begin
          exp_out[i] = v; exp_oe[i] = m_oe[i];
        end
      end
      pad_tag_oe = "R5"; pad_tag_out = "R6";
      if (bus_rd) begin
        exp_rd = '0; rd_tag = "R9";
        if (a[2:0] == 0) begin
          if (a == 0) begin exp_rd = pad_in_filt ^ m_inv; rd_tag = "R1"; end
          else if (a == 8) begin exp_rd = m_lat; rd_tag = "R2 R3"; end
          else if (a == 'h10) rd_tag = "R3";
          else if (a == 'h90) begin exp_rd = 64'h0000_0000_0000_3040; rd_tag = "R7"; end
          else if (a >= 'h400 && a < 'h600) begin
            int n;
            n = (a - 'h400) / 8;
            exp_rd[0] = m_oe[n]; exp_rd[1] = m_inv[n]; exp_rd[12] = m_od[n];
            exp_rd[25:16] = 10'(m_sel[n]);
            rd_tag = "R4";
          end
        end
      end else rd_tag = "R10";
      if (bus_wr && a[2:0] == 0) begin
        if (a == 8) m_lat = m_lat | bus_wdata;
        else if (a == 'h10) m_lat = m_lat & ~bus_wdata;
        else if (a >= 'h400 && a < 'h600) begin
          int n;
          n = (a - 'h400) / 8;
          m_oe[n] = bus_wdata[0]; m_inv[n] = bus_wdata[1]; m_od[n] = bus_wdata[12];
          m_sel[n] = int'(bus_wdata[25:16]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(bus_rdata, exp_rd, rd_tag);
      chk(pad_oe, exp_oe, pad_tag_oe);
      chk(pad_out, exp_out, pad_tag_out);
    end
  end

  task automatic op(input bit w, input bit r, input logic [11:0] ad, input logic [63:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = ad; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) op(0, 0, 12'h0, 64'h0);
  endtask

  function automatic logic [11:0] cfg_a(input int n);
    return 12'(12'h400 + 8 * n);
  endfunction

  initial begin
    pad_in_filt = 64'hA5A5_0F0F_1234_8001;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R8: reset contents read back through the port
    op(0, 1, 12'h000, 0); op(0, 1, 12'h008, 0); op(0, 1, cfg_a(0), 0);
    op(0, 1, cfg_a(63), 0); op(0, 1, 12'h090, 0); op(0, 1, 12'h010, 0);
    // R2: set then clear patterns
    op(1, 0, 12'h008, 64'hF0F0_0000_FFFF_0001); op(0, 1, 12'h008, 0);
    op(1, 0, 12'h010, 64'h3000_0000_00FF_0001); op(0, 1, 12'h008, 0);
    op(1, 0, 12'h008, 64'h0); op(0, 1, 12'h008, 0);
    // R4, R6: enable outputs, invert, open-drain, extra bits discarded
    op(1, 0, cfg_a(0), 64'hFFFF_FFFF_FC00_EFFD);
    op(1, 0, cfg_a(1), 64'h3);
    op(1, 0, cfg_a(8), 64'h1001);
    op(1, 0, cfg_a(9), 64'h1003);
    op(1, 0, cfg_a(63), 64'h1);
    op(0, 1, cfg_a(0), 0); op(0, 1, cfg_a(1), 0); op(0, 1, cfg_a(9), 0);
    op(0, 1, 12'h000, 0);
    // R5: nonzero function select keeps a line off the pad
    op(1, 0, cfg_a(62), 64'h03FF_0001); op(1, 0, 12'h008, 64'hC000_0000_0000_0000);
    op(0, 1, cfg_a(62), 0);
    op(1, 0, cfg_a(62), 64'h0000_0001); op(0, 1, cfg_a(62), 0);
    // R9, R7: ignored writes and zero reads
    op(1, 0, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF); op(1, 0, 12'h090, 64'hFFFF);
    op(1, 0, 12'h018, 64'hFFFF); op(1, 0, 12'h00C, 64'hFFFF_FFFF);
    op(1, 0, 12'h404, 64'h3); op(1, 0, 12'h600, 64'h3); op(1, 0, 12'h3F8, 64'h3);
    op(0, 1, 12'h018, 0); op(0, 1, 12'h404, 0); op(0, 1, 12'h600, 0);
    op(0, 1, 12'h090, 0); op(0, 1, 12'h008, 0); op(0, 1, cfg_a(0), 0);
    // R10: read during write sees old state, then hold
    op(1, 1, cfg_a(5), 64'h1003); op(1, 1, 12'h008, 64'h20); idle(3);
    op(0, 1, cfg_a(5), 0); idle(2);
    // mixed traffic
    for (int it = 0; it < 4000; it++) begin
      int kind;
      logic [11:0] ad;
      logic [63:0] d;
      kind = $urandom_range(0, 9);
      d = {$urandom, $urandom};
      case (kind)
        0: ad = 12'h000;
        1, 2: ad = 12'h008;
        3: ad = 12'h010;
        4: ad = 12'h090;
        5, 6, 7: begin
          ad = cfg_a($urandom_range(0, 63));
          if ($urandom_range(0, 3) != 0) d[25:16] = '0;
        end
        default: ad = 12'($urandom_range(0, 4095));
      endcase
      if ($urandom_range(0, 3) == 0) pad_in_filt = {$urandom, $urandom};
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, ad, d);
    end
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule